// File: doc/BRIEF.md
# Sampler Statistics and Histogram Monitor

This block watches a stream of signed sampler codes and hands it on unchanged, one register stage later. While the stream flows, it keeps running figures for the current integration period: how many valid samples arrived, the smallest and largest code, the signed sum, and the sum of squares. It also keeps a count for every possible code. Software divides the sums by the count to get the mean and the mean square, and takes any square root itself.

A one-cycle integration-end strobe closes the period. In the same clock edge every running figure is copied to a snapshot, and the accumulators start again from empty. The histogram uses two banks of bin counters. One bank collects the current period while the other holds the last closed period for reading, and the roles swap at each strobe. A bank that takes over collection is emptied in that same edge by clearing one valid bit per bin, so accumulation never stalls. Snapshot figures are on dedicated output ports. A histogram bin is read by placing its code on the read address; the count appears one cycle later.

A small controller has two states. ST_FIRST is entered at reset and means no period has closed yet. Its only transition, taken on the integration-end strobe, goes to ST_RUN. ST_RUN holds until reset and means the snapshot contents are valid. The controller also owns the bank-select bit, which toggles on every strobe.

Top module: `samp_stats_top`

## Requirements
- R1: `out_data` and `out_valid` equal the `in_data` and `in_valid` of the previous clock cycle, with the data bits unmodified.
- R2: `snap_count` is the number of cycles with `in_valid` high in the last closed period.
- R3: `snap_min` and `snap_max` are the signed two's-complement minimum and maximum of the valid samples in the last closed period. For an empty period they read +127 and -128 (all-ones-but-sign and sign-only at default width).
- R4: `snap_sum` is the signed sum of the valid samples in the last closed period.
- R5: `snap_sumsq` is the unsigned sum of the squares of the valid samples in the last closed period.
- R6: The histogram has one bin per code. The bin address of a sample is its raw two's-complement bit pattern, so -1 is address 255. `hist_data` shows the count of the bin at `hist_addr` one cycle after the address is applied.
- R7: A bin that reaches 2^BIN_W-1 stays at that value for any further samples of its code in the same period.
- R8: A sample presented in the same cycle as `int_end` belongs to the period being closed. A sample in the cycle right after the strobe is the first sample of the new period. No sample is lost at the boundary.
- R9: Each period's histogram starts with every bin at zero, including the bank that held data two periods earlier.
- R10: After reset `snap_valid` is 0, the snapshot reads as an empty period and every bin reads 0. `snap_valid` rises after the first `int_end` and stays high.
- R11: A cycle with `in_valid` low changes no statistic or bin, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | SAMP_W | Signed sampler code |
| int_end | input | 1 | Integration-end strobe, one cycle |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_data | output | SAMP_W | Delayed, untouched copy of in_data |
| snap_valid | output | 1 | Snapshot holds a closed period |
| snap_count | output | CNT_W | Valid-sample count of the last period |
| snap_min | output | SAMP_W | Signed minimum of the last period |
| snap_max | output | SAMP_W | Signed maximum of the last period |
| snap_sum | output | SAMP_W+CNT_W | Signed sum of the last period |
| snap_sumsq | output | 2*SAMP_W+CNT_W | Sum of squares of the last period |
| hist_addr | input | SAMP_W | Bin to read (raw code bits) |
| hist_data | output | BIN_W | Count of the addressed bin, one cycle later |

## Verification
The bench sends every one of the 256 codes with a multiplicity that differs from code to code, and scatters idle cycles carrying junk data through the stream. A design that mapped bins by offset-binary instead of raw bits, compared codes as unsigned, or let idle cycles update the figures would show wrong bins or a wrong minimum and maximum. The bench then starts a new period on the cycle right after a strobe that carries a sample, so an off-by-one at the boundary shows up in both counts. It drives one code 70 times into 6-bit bins, where a design without saturation would wrap to a small value. Finally it closes an empty period on the bank that held the first period's data, so a bank that was never cleared would show stale counts, and empty-period sentinels that were never loaded would show a wrong minimum or maximum.

// File: rtl/samp_stats_pkg.sv
package samp_stats_pkg;

    // Snapshot controller states
    typedef enum logic [0:0] {
        ST_FIRST = 1'b0,   // no integration period closed since reset
        ST_RUN   = 1'b1    // snapshot holds a closed period
    } ctl_state_e;

    // Number of histogram banks (ping-pong)
    localparam int unsigned N_BANKS = 2;

endpackage

// File: rtl/samp_stats_ctrl.sv
module samp_stats_ctrl
    import samp_stats_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_end,
    output logic act_bank,
    output logic snap_valid
);

    ctl_state_e state_q, state_d;
    logic       bank_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST: if (int_end) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_FIRST;
        endcase
    end

    // state register and bank select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (int_end) bank_q <= ~bank_q;
        end
    end

    // outputs
    always_comb begin
        act_bank   = bank_q;
        snap_valid = (state_q == ST_RUN);
    end

    // R9: the collecting bank changes at every strobe
    p_bank_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_end |=> (act_bank != $past(act_bank)));

    // R10: once valid, the snapshot stays valid
    p_snap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |=> snap_valid);

    // R10: a strobe always yields a valid snapshot
    p_snap_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_end |=> snap_valid);

endmodule

// File: rtl/samp_stats_acc.sv
module samp_stats_acc #(
    parameter int SAMP_W = 8,
    parameter int CNT_W  = 20
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic signed [SAMP_W-1:0]          in_data,
    input  logic                              int_end,
    output logic        [CNT_W-1:0]           snap_count,
    output logic signed [SAMP_W-1:0]          snap_min,
    output logic signed [SAMP_W-1:0]          snap_max,
    output logic signed [SAMP_W+CNT_W-1:0]    snap_sum,
    output logic        [2*SAMP_W+CNT_W-1:0]  snap_sumsq
);

    localparam int SUM_W = SAMP_W + CNT_W;
    localparam int SQ_W  = 2 * SAMP_W + CNT_W;
    localparam int PR_W  = 2 * SAMP_W;
    localparam logic signed [SAMP_W-1:0] CODE_HI = {1'b0, {(SAMP_W-1){1'b1}}};
    localparam logic signed [SAMP_W-1:0] CODE_LO = {1'b1, {(SAMP_W-1){1'b0}}};

    logic        [CNT_W-1:0]  cnt_q, cnt_d;
    logic signed [SAMP_W-1:0] min_q, min_d, max_q, max_d;
    logic signed [SUM_W-1:0]  sum_q, sum_d;
    logic        [SQ_W-1:0]   sq_q,  sq_d;
    logic signed [PR_W-1:0]   prod;
    logic signed [SUM_W-1:0]  samp_ext;

    // running values including the current sample
    always_comb begin
        prod     = in_data * in_data;
        samp_ext = {{(SUM_W-SAMP_W){in_data[SAMP_W-1]}}, in_data};
        cnt_d = cnt_q;
        min_d = min_q;
        max_d = max_q;
        sum_d = sum_q;
        sq_d  = sq_q;
        if (in_valid) begin
            cnt_d = cnt_q + 1'b1;
            if (in_data < min_q) min_d = in_data;
            if (in_data > max_q) max_d = in_data;
            sum_d = sum_q + samp_ext;
            sq_d  = sq_q + {{(SQ_W-PR_W){1'b0}}, prod};
        end
    end

    // running accumulators
    always_ff @(posedge clk) begin
        if (!rst_n || int_end) begin
            cnt_q <= '0;
            min_q <= CODE_HI;
            max_q <= CODE_LO;
            sum_q <= '0;
            sq_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            min_q <= min_d;
            max_q <= max_d;
            sum_q <= sum_d;
            sq_q  <= sq_d;
        end
    end

    // snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_count <= '0;
            snap_min   <= CODE_HI;
            snap_max   <= CODE_LO;
            snap_sum   <= '0;
            snap_sumsq <= '0;
        end else if (int_end) begin
            snap_count <= cnt_d;
            snap_min   <= min_d;
            snap_max   <= max_d;
            snap_sum   <= sum_d;
            snap_sumsq <= sq_d;
        end
    end

    // R3: a non-empty snapshot never has min above max
    p_min_le_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_count != '0) |-> (snap_min <= snap_max));

    // R8: accumulation restarts empty after a strobe
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_end |=> (cnt_q == '0));

    // R11: idle cycles leave the running figures alone
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !int_end) |=> ($stable(sum_q) && $stable(sq_q) &&
                                     $stable(min_q) && $stable(max_q)));

endmodule

// File: rtl/samp_stats_hist.sv
module samp_stats_hist
    import samp_stats_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int BIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_code,
    input  logic              int_end,
    input  logic              act_bank,
    input  logic [SAMP_W-1:0] rd_addr,
    output logic [BIN_W-1:0]  rd_data
);

    localparam int N_BINS = 1 << SAMP_W;
    localparam logic [BIN_W-1:0] BIN_MAX = '1;

    logic [BIN_W-1:0] cur_val [N_BANKS];
    logic [BIN_W-1:0] rd_val  [N_BANKS];
    logic [BIN_W-1:0] cur_sel, inc_val;

    always_comb begin
        cur_sel = cur_val[act_bank];
        inc_val = (cur_sel == BIN_MAX) ? BIN_MAX : cur_sel + 1'b1;
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [BIN_W-1:0]  mem [N_BINS];
        logic [N_BINS-1:0] live;
        logic              we, clr;

        assign we  = in_valid && (act_bank == 1'(b));
        assign clr = int_end  && (act_bank != 1'(b));

        // bin storage, no reset: validity comes from live bits
        always_ff @(posedge clk) begin
            if (we) mem[in_code] <= inc_val;
        end

        // per-bin valid bits, cleared in one edge when the bank takes over
        always_ff @(posedge clk) begin
            if (!rst_n || clr) live <= '0;
            else if (we)       live[in_code] <= 1'b1;
        end

        assign cur_val[b] = live[in_code] ? mem[in_code] : '0;
        assign rd_val[b]  = live[rd_addr] ? mem[rd_addr] : '0;
    end

    // registered read of the bank that is not collecting
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_val[!act_bank];
    end

    // R7: a bin hit on consecutive cycles never decreases (no wrap)
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && (in_code == $past(in_code)) &&
         (act_bank == $past(act_bank)) && !$past(int_end))
        |-> (cur_sel >= $past(cur_sel)) && (cur_sel != '0));

endmodule

// File: rtl/samp_stats_top.sv
module samp_stats_top #(
    parameter int SAMP_W = 8,
    parameter int CNT_W  = 20,
    parameter int BIN_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [SAMP_W-1:0]           in_data,
    input  logic                        int_end,
    output logic                        out_valid,
    output logic [SAMP_W-1:0]           out_data,
    output logic                        snap_valid,
    output logic [CNT_W-1:0]            snap_count,
    output logic [SAMP_W-1:0]           snap_min,
    output logic [SAMP_W-1:0]           snap_max,
    output logic [SAMP_W+CNT_W-1:0]     snap_sum,
    output logic [2*SAMP_W+CNT_W-1:0]   snap_sumsq,
    input  logic [SAMP_W-1:0]           hist_addr,
    output logic [BIN_W-1:0]            hist_data
);

    logic act_bank;

    // untouched pass-through stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data;
        end
    end

    samp_stats_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_end    (int_end),
        .act_bank   (act_bank),
        .snap_valid (snap_valid)
    );

    samp_stats_acc #(
        .SAMP_W (SAMP_W),
        .CNT_W  (CNT_W)
    ) i_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .int_end    (int_end),
        .snap_count (snap_count),
        .snap_min   (snap_min),
        .snap_max   (snap_max),
        .snap_sum   (snap_sum),
        .snap_sumsq (snap_sumsq)
    );

    samp_stats_hist #(
        .SAMP_W (SAMP_W),
        .BIN_W  (BIN_W)
    ) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_code  (in_data),
        .int_end  (int_end),
        .act_bank (act_bank),
        .rd_addr  (hist_addr),
        .rd_data  (hist_data)
    );

    // R1: valid samples come out one cycle later with the same bits
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && (out_data == $past(in_data))));

endmodule

// File: tb/test_samp_stats_top.sv
module test_samp_stats_top;

    localparam int CLK_PERIOD = 10;
    localparam int SAMP_W = 8;
    localparam int CNT_W  = 16;
    localparam int BIN_W  = 6;
    localparam int BMAX   = (1 << BIN_W) - 1;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic                      in_valid;
    logic [SAMP_W-1:0]         in_data;
    logic                      int_end;
    logic                      out_valid;
    logic [SAMP_W-1:0]         out_data;
    logic                      snap_valid;
    logic [CNT_W-1:0]          snap_count;
    logic [SAMP_W-1:0]         snap_min, snap_max;
    logic [SAMP_W+CNT_W-1:0]   snap_sum;
    logic [2*SAMP_W+CNT_W-1:0] snap_sumsq;
    logic [SAMP_W-1:0]         hist_addr;
    logic [BIN_W-1:0]          hist_data;

    int checks = 0;
    int errors = 0;
    int idle_ctr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    samp_stats_top #(
        .SAMP_W (SAMP_W),
        .CNT_W  (CNT_W),
        .BIN_W  (BIN_W)
    ) i_samp_stats_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .int_end    (int_end),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .snap_valid (snap_valid),
        .snap_count (snap_count),
        .snap_min   (snap_min),
        .snap_max   (snap_max),
        .snap_sum   (snap_sum),
        .snap_sumsq (snap_sumsq),
        .hist_addr  (hist_addr),
        .hist_data  (hist_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // one valid sample, optionally with the strobe; checks pass-through (R1)
    task automatic put(input int v, input bit e);
        in_valid = 1'b1;
        in_data  = SAMP_W'(v);
        int_end  = e;
        @(negedge clk);
        in_valid = 1'b0;
        int_end  = 1'b0;
        chk("R1 out_valid", longint'(out_valid), 1);
        chk("R1 out_data", longint'(out_data), longint'(v & 255));
    endtask

    // idle cycle with junk data (R11)
    task automatic idle(input int junk);
        in_valid = 1'b0;
        in_data  = SAMP_W'(junk);
        @(negedge clk);
        chk("R11 out_valid idle", longint'(out_valid), 0);
    endtask

    task automatic strobe();
        int_end = 1'b1;
        @(negedge clk);
        int_end = 1'b0;
    endtask

    task automatic check_snap(input string tag, input longint c, input longint mn,
                              input longint mx, input longint s, input longint q);
        chk({tag, " R2 count"}, longint'(snap_count), c);
        chk({tag, " R3 min"}, longint'($signed(snap_min)), mn);
        chk({tag, " R3 max"}, longint'($signed(snap_max)), mx);
        chk({tag, " R4 sum"}, longint'($signed(snap_sum)), s);
        chk({tag, " R5 sumsq"}, longint'(snap_sumsq), q);
    endtask

    function automatic int mult_a(input int v);
        return ((v + 128) % 3) + 1;
    endfunction

    initial begin
        longint ec, es, eq;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; int_end = 1'b0; hist_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 snap_valid after reset", longint'(snap_valid), 0);
        check_snap("R10 reset", 0, 127, -128, 0, 0);
        chk("R10 bin after reset", longint'(hist_data), 0);

        // Period A: every code, varying multiplicity, idle junk sprinkled in
        ec = 0; es = 0; eq = 0;
        for (int v = -128; v < 128; v++) begin
            for (int r = 0; r < mult_a(v); r++) begin
                ec++; es += v; eq += longint'(v * v);
                idle_ctr++;
                if (idle_ctr % 7 == 0) idle(v * 37 + 11);
                put(v, (v == 127) && (r == mult_a(v) - 1)); // R8: last sample rides the strobe
            end
        end
        // Period B starts on the very next cycle (R8)
        for (int i = 0; i < 70; i++) put(5, 1'b0);
        put(-3, 1'b0);
        put(-3, 1'b0);

        chk("R10 snap_valid after first strobe", longint'(snap_valid), 1);
        check_snap("A", ec, -128, 127, es, eq);
        for (int a = 0; a < 256; a++) begin
            int v;
            v = (a < 128) ? a : a - 256;
            hist_addr = SAMP_W'(a);
            @(negedge clk);
            chk("R6 bin A", longint'(hist_data), longint'(mult_a(v)));
        end

        // Close B; check saturation and stats
        strobe();
        check_snap("B R8", 72, -3, 5, 344, 1768);
        for (int a = 0; a < 256; a++) begin
            longint exp;
            exp = (a == 5) ? BMAX : ((a == 253) ? 2 : 0);
            hist_addr = SAMP_W'(a);
            @(negedge clk);
            chk((a == 5) ? "R7 saturated bin" : "R6 bin B", longint'(hist_data), exp);
        end

        // Period C: empty, collected in the bank that held A (R9)
        idle(99);
        strobe();
        check_snap("C R3 empty", 0, 127, -128, 0, 0);
        for (int a = 0; a < 256; a++) begin
            hist_addr = SAMP_W'(a);
            @(negedge clk);
            chk("R9 bin after reuse", longint'(hist_data), 0);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule